// File: doc/BRIEF.md
# Digital IO Port with Edge Interrupt Status

An eight-line bidirectional digital port combined with a board-level interrupt status register and its enable register. The host writes one control word that holds the output data, the direction of each group of four lines, and the edge that raises an interrupt on each line. The lower four lines each have their own edge select. The upper four lines share one edge select. Reading the control word returns the current pin levels in its low byte.

Every input line passes through a two-flop synchronizer and then an edge detector. A detected edge on a line that is an input sets that line's bit in the status register. The status register also collects single-cycle pulses from other on-board sources: a timer, analog output done, analog input done, four counters and a non-volatile memory done event. The host clears status bits by writing ones. The single interrupt output is high while any status bit is set and also enabled.

Top module: `dio_irq_port`

## Requirements
- R1: After reset the control word is 0, all lines are inputs (`pin_oe` = 0), the status and enable registers read 0, and `irq` is low.
- R2: Control bits 7:0 drive `pin_out`. In `ctrl_rd`, bits 7:0 give the driven value for output lines and the synchronized `pin_in` level for input lines. Bit 9 reads 0.
- R3: Control bit 10 makes lines 0-3 outputs and bit 11 makes lines 4-7 outputs. Direction is set only per group of four.
- R4: Control bit 12+n (n = 0..3) selects the interrupt edge of line n, with 1 = falling and 0 = rising. Control bit 8 selects one edge for all of lines 4-7 with the same encoding. An edge of the other polarity sets nothing.
- R5: A line configured as an output never sets its status bit, whatever `pin_in` does.
- R6: Status layout: DIO line n sets bit 8+n. The memory-done pulse sets bit 7. Counter x pulse sets bit 6-x, so counter 0 is bit 6 and counter 3 is bit 3. Analog input done sets bit 2, analog output done sets bit 1 and the timer sets bit 0.
- R7: A status write (`wr_sel` = 2) clears every bit written as 1 and leaves the bits written as 0 unchanged.
- R8: The memory-done bit has no enable. Enable bit 7 always reads 0, and status bit 7 never raises `irq`.
- R9: A status bit sets on its event even while disabled. `irq` equals the OR of (status AND enable), so it stays high until the host clears the bit or disables it.
- R10: When a clear write and a new event hit the same status bit in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target: 0 control, 1 enable, 2 status clear, 3 none |
| wr_data | input | 16 | Write data |
| ctrl_rd | output | 16 | Control word readback with pin levels in bits 7:0 |
| int_enable | output | 16 | Interrupt enable register |
| int_status | output | 16 | Interrupt status register |
| irq | output | 1 | Interrupt request |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Pin drive values |
| pin_oe | output | 8 | Pin output enables |
| ev_timer | input | 1 | Timer event pulse |
| ev_ao_done | input | 1 | Analog output done pulse |
| ev_ai_done | input | 1 | Analog input done pulse |
| ev_cntr | input | 4 | Counter event pulses, bit x = counter x |
| ev_mem_done | input | 1 | Non-volatile memory done pulse |

## Verification
Assertions check on every cycle that cleared bits drop unless an event hits them, that events win over a clear in the same cycle, that `irq` holds while nothing clears or disables it, that output-configured lines leave the DIO status bits alone, and that the timer pulse lands in bit 0. The bench scenarios cover the rest: the full status bit mapping including the reversed counter order, per-line and shared edge polarity, pin readback, and the masking of the memory-done enable.

// File: rtl/dio_irq_pkg.sv
package dio_irq_pkg;
    localparam int NLINES = 8;
    localparam int GRP    = 4;
    localparam int SYNC_N = 2;
    localparam int SW     = 16;
    localparam int NCNTR  = 4;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_ENA  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [GRP-1:0] lo_fall;  // 15:12
        logic           hi_oe;    // 11
        logic           lo_oe;    // 10
        logic           rsv;      // 9
        logic           hi_fall;  // 8
        logic [7:0]     data;     // 7:0
    } dio_ctrl_t;

    localparam logic [SW-1:0] ENA_MASK = 16'hFF7F;

    function automatic logic [SW-1:0] pack_status(
        input logic [NLINES-1:0] dio,
        input logic              mem,
        input logic [NCNTR-1:0]  cntr,
        input logic              ai,
        input logic              ao,
        input logic              tmr);
        logic [SW-1:0] v;
        v = '0;
        v[15:8] = dio;
        v[7]    = mem;
        for (int x = 0; x < NCNTR; x++) v[6-x] = cntr[x];
        v[2] = ai;
        v[1] = ao;
        v[0] = tmr;
        return v;
    endfunction
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dio_edge_det.sv
module dio_edge_det #(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] level,
    input  logic [LINES-1:0] is_out,
    input  logic [LINES-1:0] fall_sel,
    output logic [LINES-1:0] evt
);
    logic [LINES-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= level;
    end

    for (genvar n = 0; n < LINES; n++) begin : g_line
        logic rise, fall;
        assign rise   = level[n] & ~prev[n];
        assign fall   = ~level[n] & prev[n];
        assign evt[n] = ~is_out[n] & (fall_sel[n] ? fall : rise);
    end
endmodule

// File: rtl/dio_irq_status.sv
module dio_irq_status #(
    parameter int            W    = 16,
    parameter logic [W-1:0]  MASK = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_vec,
    input  logic         clr_we,
    input  logic [W-1:0] clr_vec,
    input  logic         ena_we,
    input  logic [W-1:0] ena_vec,
    output logic [W-1:0] status,
    output logic [W-1:0] enable,
    output logic         irq
);
    logic [W-1:0] clr_eff;
    assign clr_eff = clr_we ? clr_vec : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            enable <= '0;
        end else begin
            status <= (status & ~clr_eff) | set_vec;
            if (ena_we) enable <= ena_vec & MASK;
        end
    end

    assign irq = |(status & enable);

    // R7: bits cleared without a coincident event are low next cycle
    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((status & $past(clr_vec & ~set_vec)) == '0));

    // R10: an event wins over a same-cycle clear
    a_r10_event_wins: assert property (@(posedge clk) disable iff (rst)
        (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec)));

    // R9: irq holds while nothing clears or rewrites the enables
    a_r9_irq_hold: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr_we && !ena_we) |=> irq);
endmodule

// File: rtl/dio_irq_port.sv
module dio_irq_port
    import dio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [SW-1:0]     wr_data,
    output logic [SW-1:0]     ctrl_rd,
    output logic [SW-1:0]     int_enable,
    output logic [SW-1:0]     int_status,
    output logic              irq,
    input  logic [NLINES-1:0] pin_in,
    output logic [NLINES-1:0] pin_out,
    output logic [NLINES-1:0] pin_oe,
    input  logic              ev_timer,
    input  logic              ev_ao_done,
    input  logic              ev_ai_done,
    input  logic [NCNTR-1:0]  ev_cntr,
    input  logic              ev_mem_done
);
    dio_ctrl_t        ctrl;
    logic [NLINES-1:0] pin_sync, fall_sel, dio_evt;
    logic [SW-1:0]     set_vec;
    reg_sel_e          sel;

    assign sel = reg_sel_e'(wr_sel);

    always_ff @(posedge clk) begin
        if (rst)                          ctrl <= '0;
        else if (wr_en && sel == SEL_CTRL) begin
            ctrl     <= dio_ctrl_t'(wr_data);
            ctrl.rsv <= 1'b0;
        end
    end

    for (genvar n = 0; n < NLINES; n++) begin : g_cfg
        if (n < GRP) begin : g_lo
            assign pin_oe[n]   = ctrl.lo_oe;
            assign fall_sel[n] = ctrl.lo_fall[n];
        end else begin : g_hi
            assign pin_oe[n]   = ctrl.hi_oe;
            assign fall_sel[n] = ctrl.hi_fall;
        end
    end

    assign pin_out = ctrl.data;

    dio_sync #(.WIDTH(NLINES), .STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst(rst), .d(pin_in), .q(pin_sync));

    dio_edge_det #(.LINES(NLINES)) u_edge (
        .clk(clk), .rst(rst), .level(pin_sync), .is_out(pin_oe),
        .fall_sel(fall_sel), .evt(dio_evt));

    assign set_vec = pack_status(dio_evt, ev_mem_done, ev_cntr,
                                 ev_ai_done, ev_ao_done, ev_timer);

    dio_irq_status #(.W(SW), .MASK(ENA_MASK)) u_stat (
        .clk(clk), .rst(rst), .set_vec(set_vec),
        .clr_we(wr_en && sel == SEL_STAT), .clr_vec(wr_data),
        .ena_we(wr_en && sel == SEL_ENA), .ena_vec(wr_data),
        .status(int_status), .enable(int_enable), .irq(irq));

    always_comb begin
        ctrl_rd      = ctrl;
        ctrl_rd[7:0] = (pin_oe & ctrl.data) | (~pin_oe & pin_sync);
    end

    // R5: with every line an output the DIO status bits never gain a bit
    a_r5_out_no_dio_irq: assert property (@(posedge clk) disable iff (rst)
        (&pin_oe) |=> ((int_status[15:8] & ~$past(int_status[15:8])) == '0));

    // R6: the timer pulse lands in status bit 0
    a_r6_timer_bit: assert property (@(posedge clk) disable iff (rst)
        ev_timer |=> int_status[0]);
endmodule

// File: tb/dio_irq_port_test.sv
module dio_irq_port_test;
    logic        clk = 0;
    logic        rst = 1;
    logic        wr_en = 0;
    logic [1:0]  wr_sel = 3;
    logic [15:0] wr_data = 0;
    logic [15:0] ctrl_rd, int_enable, int_status;
    logic        irq;
    logic [7:0]  pin_in = 0, pin_out, pin_oe;
    logic        ev_timer = 0, ev_ao_done = 0, ev_ai_done = 0, ev_mem_done = 0;
    logic [3:0]  ev_cntr = 0;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dio_irq_port uut (.*);

    // {source id, expected status}: 0 timer,1 ao,2 ai,3..6 counter 0..3,7 mem
    localparam logic [19:0] VEC [8] = '{
        {4'd0, 16'h0001}, {4'd1, 16'h0002}, {4'd2, 16'h0004},
        {4'd3, 16'h0040}, {4'd4, 16'h0020}, {4'd5, 16'h0010},
        {4'd6, 16'h0008}, {4'd7, 16'h0080}};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        wr_en = 1; wr_sel = s; wr_data = d;
        step(1);
        wr_en = 0; wr_sel = 3; wr_data = 0;
    endtask

    task automatic pulse(input int id);
        case (id)
            0: ev_timer = 1;
            1: ev_ao_done = 1;
            2: ev_ai_done = 1;
            7: ev_mem_done = 1;
            default: ev_cntr[id-3] = 1;
        endcase
        step(1);
        ev_timer = 0; ev_ao_done = 0; ev_ai_done = 0; ev_mem_done = 0; ev_cntr = 0;
    endtask

    initial begin
        step(3);
        rst = 0;
        step(1);
        // R1 reset state
        chk("R1 ctrl", ctrl_rd, 16'h0000);
        chk("R1 oe", pin_oe, 8'h00);
        chk("R1 status", int_status, 16'h0000);
        chk("R1 enable", int_enable, 16'h0000);
        chk("R1 irq", irq, 1'b0);

        // R6 status mapping walked from the table
        for (int i = 0; i < 8; i++) begin
            pulse(int'(VEC[i][19:16]));
            chk("R6 map", int_status, VEC[i][15:0]);
            wr(2, 16'hFFFF);
            chk("R7 clear all", int_status, 16'h0000);
        end

        // R2/R3 direction, drive and readback
        wr(0, 16'h06A5);
        chk("R3 oe low group", pin_oe, 8'h0F);
        chk("R2 pin_out", pin_out, 8'hA5);
        pin_in = 8'h30;
        step(3);
        chk("R2 readback", ctrl_rd, 16'h0435);
        wr(0, 16'h0800);
        chk("R3 oe high group", pin_oe, 8'hF0);
        pin_in = 8'h00;
        wr(2, 16'hFFFF);
        step(4);
        wr(2, 16'hFFFF);

        // R4 edges, all inputs, rising everywhere
        wr(0, 16'h0000);
        step(4);
        wr(2, 16'hFFFF);
        pin_in[0] = 1; step(4);
        chk("R4 line0 rise", int_status, 16'h0100);
        wr(2, 16'hFFFF);
        pin_in[0] = 0; step(4);
        chk("R4 line0 fall ignored", int_status, 16'h0000);
        wr(0, 16'h1000);             // line0 falling
        pin_in[0] = 1; step(4);
        chk("R4 line0 rise ignored", int_status, 16'h0000);
        pin_in[0] = 0; step(4);
        chk("R4 line0 fall", int_status, 16'h0100);
        wr(2, 16'hFFFF);
        wr(0, 16'h0100);             // upper group falling
        pin_in[5] = 1; step(4);
        chk("R4 line5 rise ignored", int_status, 16'h0000);
        pin_in[5] = 0; step(4);
        chk("R4 line5 fall", int_status, 16'h2000);
        wr(2, 16'hFFFF);

        // R5 outputs raise nothing
        wr(0, 16'h0C00);
        pin_in = 8'hFF; step(4);
        pin_in = 8'h00; step(4);
        chk("R5 outputs quiet", int_status, 16'h0000);
        wr(0, 16'h0000);
        step(4);
        wr(2, 16'hFFFF);

        // R7 partial clear
        pulse(0); pulse(1); pulse(2);
        wr(2, 16'h0002);
        chk("R7 partial clear", int_status, 16'h0005);
        wr(2, 16'h0005);

        // R8 memory-done enable masked
        wr(1, 16'hFFFF);
        chk("R8 enable mask", int_enable, 16'hFF7F);
        pulse(7);
        chk("R8 mem status", int_status, 16'h0080);
        chk("R8 no irq", irq, 1'b0);
        wr(2, 16'hFFFF);
        wr(1, 16'h0000);

        // R9 sets while disabled, irq follows enable and holds
        pulse(0);
        chk("R9 set while disabled", int_status, 16'h0001);
        chk("R9 irq low", irq, 1'b0);
        wr(1, 16'h0001);
        step(5);
        chk("R9 irq held", irq, 1'b1);
        wr(2, 16'h0001);
        chk("R9 irq cleared", irq, 1'b0);

        // R10 event beats clear
        ev_timer = 1; wr_en = 1; wr_sel = 2; wr_data = 16'h0001;
        step(1);
        ev_timer = 0; wr_en = 0; wr_sel = 3; wr_data = 0;
        chk("R10 event wins", int_status, 16'h0001);
        chk("R10 irq", irq, 1'b1);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                fails++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule